// File: doc/BRIEF.md
# Framed Link Loopback Selector

This block sits on the transmit side of a framed serial link, between the receive deframer and the transmit framer. For every outgoing word position it decides whether the framer sends the locally generated word or the matching word that arrived on the receive side. The choice follows a 3-bit loop mode and a class tag that comes with each word position. The tag separates IQ sample data, management data, management control, vendor-specific control and other control words. Received words pass through a fixed-depth delay line, so that each one lines up with the transmit word position it would replace.

Looping is armed only when the link reports frame synchronization and the block is strapped as a slave. A physical-layer loop bit overrides the selector completely: while it is set, the local word goes out untouched. A transmit-enable bit gates the output, and while the gate is closed the block sends an idle, invalid word. A force bit can open the gate without a connected master, but only in slave role, so that a slave can be tested for self-synchronization. The decision and the output word are registered, so each result appears one clock after its inputs.

Top module: `floop_sel`

## Requirements
- R1: With loop mode 3'b000 every valid output word is the local word and the received-source flag stays low.
- R2: With loop mode 3'b001 and the loop armed, every word class (tag values 0 to 7) takes the delayed received word.
- R3: With loop mode 3'b010 and the loop armed, only class 0 (IQ data) takes the received word. Classes 1 to 7 take the local word.
- R4: With loop mode 3'b011 and the loop armed, class 1 (management data) and class 2 (management control) take the received word. Every other class takes the local word.
- R5: With loop mode 3'b100 and the loop armed, class 2 (management control) and class 3 (vendor-specific control) take the received word. Every other class takes the local word.
- R6: Loop mode codes 3'b101, 3'b110 and 3'b111 behave as 3'b000.
- R7: The loop is armed only while frame_sync and is_slave are both high. Otherwise every nonzero mode behaves as 3'b000, and a drop of frame_sync returns the output to local words on the next output word.
- R8: While phy_loop is high, the output word is the local word whatever the loop mode is, and the received-source flag is low.
- R9: When the transmit gate is closed, the next output has tx_valid low and tx_word equal to zero. The gate is open when tx_en is high, or when tx_force is high and is_slave is high.
- R10: tx_force opens the transmit gate only in slave role. In master role, tx_force with tx_en low gives an idle output.
- R11: A received word reaches the output exactly DLY clock cycles plus one output register after it is presented on rx_word (DLY defaults to 4).
- R12: The output is registered, with one cycle of latency from the class tag and controls. During reset, and after it, tx_valid, tx_word and tx_from_rx are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_word | input | W | Locally generated word for the current transmit position |
| rx_word | input | W | Received word from the deframer, before alignment |
| word_cls | input | 3 | Class tag of the current transmit position |
| loop_mode | input | 3 | Loop mode select |
| frame_sync | input | 1 | Receive frame synchronization reached |
| is_slave | input | 1 | Configuration strap, high for slave role |
| phy_loop | input | 1 | Physical-layer loop active, overrides this selector |
| tx_en | input | 1 | Transmit enable |
| tx_force | input | 1 | Force transmit enable for slave self-sync testing |
| tx_word | output | W | Word handed to the framer, zero when idle |
| tx_valid | output | 1 | Output word is valid for transmission |
| tx_from_rx | output | 1 | Output word came from the received stream |

## Verification
The bench walks all eight class tags under each loop mode. A selector that mixes up the management and vendor-specific subsets would send the wrong source for classes 1 to 3 under modes 3'b011 and 3'b100. Reserved mode codes, a master strap, missing frame sync and a set phy_loop each have to leave the output on local words. A design that armed the loop too early, or let the physical loop through, would send delayed received values in those cases instead. Frame sync is also dropped in the middle of a loop, to show the fall-back happens on the very next word. Force-enable is tried in both roles, and an off-by-one delay line shows up as a received value one index away from the expected one.

// File: rtl/floop_pkg.sv
// floop_pkg: shared class-tag and loop-mode codes for the loopback selector.
// Assumes a 3-bit class tag supplied by the word classifier upstream.
package floop_pkg;
    localparam logic [2:0] CLS_IQ      = 3'd0;
    localparam logic [2:0] CLS_MGMT_D  = 3'd1;
    localparam logic [2:0] CLS_MGMT_C  = 3'd2;
    localparam logic [2:0] CLS_VEND_C  = 3'd3;

    localparam logic [2:0] LM_OFF      = 3'd0;
    localparam logic [2:0] LM_ALL      = 3'd1;
    localparam logic [2:0] LM_IQ       = 3'd2;
    localparam logic [2:0] LM_MGMT     = 3'd3;
    localparam logic [2:0] LM_MGMT_VND = 3'd4;
endpackage

// File: rtl/floop_rx_align.sv
// floop_rx_align: fixed-depth delay line that lines received words up with
// the transmit word position. Assumes the latency between the two sides is a
// constant DEPTH cycles. Resets all stages to zero.
module floop_rx_align #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0][W-1:0] stg;

    // Shift the received word one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[LAST];
endmodule

// File: rtl/floop_ctrl.sv
// floop_ctrl: derives the transmit gate and the loop-arm condition from the
// enable bits, the role strap, frame sync and the physical-loop override.
// Purely combinational; the top registers its effect.
module floop_ctrl (
    input  logic frame_sync,
    input  logic is_slave,
    input  logic phy_loop,
    input  logic tx_en,
    input  logic tx_force,
    output logic gate_open,
    output logic loop_armed
);
    // Open the gate on enable, or on force in slave role only.
    always_comb gate_open = tx_en | (tx_force & is_slave);

    // Loop only after sync in slave role, never under the physical loop.
    always_comb loop_armed = frame_sync & is_slave & ~phy_loop;
endmodule

// File: rtl/floop_pick.sv
// floop_pick: decides, per word position, whether the received word replaces
// the local one, from the loop mode and the class tag. Reserved modes pick
// the local word. Combinational.
module floop_pick
    import floop_pkg::*;
(
    input  logic [2:0] loop_mode,
    input  logic [2:0] word_cls,
    input  logic       loop_armed,
    output logic       take_rx
);
    logic mode_hit;

    // Class subset looped back by each mode.
    always_comb begin
        unique case (loop_mode)
            LM_ALL:      mode_hit = 1'b1;
            LM_IQ:       mode_hit = (word_cls == CLS_IQ);
            LM_MGMT:     mode_hit = (word_cls == CLS_MGMT_D) || (word_cls == CLS_MGMT_C);
            LM_MGMT_VND: mode_hit = (word_cls == CLS_MGMT_C) || (word_cls == CLS_VEND_C);
            default:     mode_hit = 1'b0;
        endcase
    end

    // Qualify the class decision with the arm condition.
    always_comb take_rx = mode_hit & loop_armed;
endmodule

// File: rtl/floop_sel.sv
// floop_sel: framed link loopback selector. Chooses per transmit word between
// the local word and the aligned received word, gates transmission, and
// registers the result. Assumes word_cls, loc_word and the controls refer to
// the same transmit position, and that rx_word leads it by DLY cycles.
module floop_sel #(
    parameter int W   = 16,
    parameter int DLY = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] loc_word,
    input  logic [W-1:0] rx_word,
    input  logic [2:0]   word_cls,
    input  logic [2:0]   loop_mode,
    input  logic         frame_sync,
    input  logic         is_slave,
    input  logic         phy_loop,
    input  logic         tx_en,
    input  logic         tx_force,
    output logic [W-1:0] tx_word,
    output logic         tx_valid,
    output logic         tx_from_rx
);
    logic [W-1:0] rx_aligned;
    logic         gate_open;
    logic         loop_armed;
    logic         take_rx;

    floop_rx_align #(.W(W), .DEPTH(DLY)) u_align (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_word),
        .dout (rx_aligned)
    );

    floop_ctrl u_ctrl (
        .frame_sync(frame_sync),
        .is_slave  (is_slave),
        .phy_loop  (phy_loop),
        .tx_en     (tx_en),
        .tx_force  (tx_force),
        .gate_open (gate_open),
        .loop_armed(loop_armed)
    );

    floop_pick u_pick (
        .loop_mode (loop_mode),
        .word_cls  (word_cls),
        .loop_armed(loop_armed),
        .take_rx   (take_rx)
    );

    // Register the chosen word, or idle when the gate is closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word    <= '0;
            tx_valid   <= 1'b0;
            tx_from_rx <= 1'b0;
        end else if (!gate_open) begin
            tx_word    <= '0;
            tx_valid   <= 1'b0;
            tx_from_rx <= 1'b0;
        end else begin
            tx_word    <= take_rx ? rx_aligned : loc_word;
            tx_valid   <= 1'b1;
            tx_from_rx <= take_rx;
        end
    end
endmodule

// File: rtl/floop_chk.sv
// floop_chk: assertion checker for floop_sel, attached by bind below.
module floop_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] loc_word,
    input logic [2:0]   word_cls,
    input logic [2:0]   loop_mode,
    input logic         frame_sync,
    input logic         is_slave,
    input logic         phy_loop,
    input logic         tx_en,
    input logic         tx_force,
    input logic [W-1:0] tx_word,
    input logic         tx_valid,
    input logic         tx_from_rx
);
    logic open_now;
    always_comb open_now = tx_en | (tx_force & is_slave);

    p_off_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_mode == 3'd0) |=> !tx_from_rx);

    p_all_loop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_mode == 3'd1 && frame_sync && is_slave && !phy_loop && open_now) |=> tx_from_rx);

    p_iq_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_mode == 3'd2 && word_cls != 3'd0) |=> !tx_from_rx);

    p_mgmt_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_mode == 3'd3 && word_cls != 3'd1 && word_cls != 3'd2) |=> !tx_from_rx);

    p_mgmt_vnd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_mode == 3'd4 && word_cls != 3'd2 && word_cls != 3'd3) |=> !tx_from_rx);

    p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_mode >= 3'd5) |=> !tx_from_rx);

    p_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync || !is_slave) |=> !tx_from_rx);

    p_phy_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_loop && open_now) |=> (tx_word == $past(loc_word) && !tx_from_rx));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !open_now |=> (!tx_valid && tx_word == '0));

    p_force_master_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_slave && !tx_en) |=> !tx_valid);

    p_src_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_from_rx |-> tx_valid);
endmodule

bind floop_sel floop_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_word  (loc_word),
    .word_cls  (word_cls),
    .loop_mode (loop_mode),
    .frame_sync(frame_sync),
    .is_slave  (is_slave),
    .phy_loop  (phy_loop),
    .tx_en     (tx_en),
    .tx_force  (tx_force),
    .tx_word   (tx_word),
    .tx_valid  (tx_valid),
    .tx_from_rx(tx_from_rx)
);

// File: tb/sim_floop_sel.sv
// sim_floop_sel: directed bench for floop_sel, one task per scenario.
module sim_floop_sel;
    localparam int W   = 16;
    localparam int DLY = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] loc_word = '0;
    logic [W-1:0] rx_word = '0;
    logic [2:0]   word_cls = '0;
    logic [2:0]   loop_mode = '0;
    logic         frame_sync = 1'b0;
    logic         is_slave = 1'b0;
    logic         phy_loop = 1'b0;
    logic         tx_en = 1'b0;
    logic         tx_force = 1'b0;
    logic [W-1:0] tx_word;
    logic         tx_valid;
    logic         tx_from_rx;

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    floop_sel #(.W(W), .DLY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .loc_word(loc_word), .rx_word(rx_word),
        .word_cls(word_cls), .loop_mode(loop_mode), .frame_sync(frame_sync),
        .is_slave(is_slave), .phy_loop(phy_loop), .tx_en(tx_en),
        .tx_force(tx_force), .tx_word(tx_word), .tx_valid(tx_valid),
        .tx_from_rx(tx_from_rx)
    );

    function automatic logic [W-1:0] rxv(int k);
        return 16'hA000 | 16'(k & 12'hFFF);
    endfunction

    function automatic logic [W-1:0] locv(int k);
        return 16'h5000 | 16'(k & 12'hFFF);
    endfunction

    // Expected source choice, written from R1 to R8.
    function automatic bit want_rx(logic [2:0] m, logic [2:0] c);
        bit armed;
        bit hit;
        armed = frame_sync && is_slave && !phy_loop;
        case (m)
            3'd1:    hit = 1;
            3'd2:    hit = (c == 3'd0);
            3'd3:    hit = (c == 3'd1) || (c == 3'd2);
            3'd4:    hit = (c == 3'd2) || (c == 3'd3);
            default: hit = 0;
        endcase
        return armed && hit;
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Present one word position, then check the registered output.
    task automatic step(logic [2:0] c, string tag);
        bit          ev;
        bit          er;
        logic [W-1:0] ew;
        loc_word = locv(n);
        rx_word  = rxv(n);
        word_cls = c;
        ev = tx_en || (tx_force && is_slave);
        er = ev && want_rx(loop_mode, c);
        ew = !ev ? '0 : (er ? rxv(n - DLY) : locv(n));
        @(posedge clk);
        @(negedge clk);
        check({tag, " word"},  tx_word, ew);
        check({tag, " valid"}, 16'(tx_valid), 16'(ev));
        check({tag, " src"},   16'(tx_from_rx), 16'(er));
        n++;
    endtask

    task automatic t_reset;
        check("R12 reset word",  tx_word, '0);
        check("R12 reset valid", 16'(tx_valid), 16'd0);
        check("R12 reset src",   16'(tx_from_rx), 16'd0);
    endtask

    task automatic t_warmup;
        tx_en = 1; loop_mode = 3'd0;
        for (int i = 0; i < DLY + 2; i++) step(3'd0, "R1 warmup");
    endtask

    task automatic t_modes;
        frame_sync = 1; is_slave = 1; tx_en = 1;
        for (int m = 0; m < 8; m++) begin
            loop_mode = 3'(m);
            for (int c = 0; c < 8; c++) begin
                case (m)
                    0:       step(3'(c), "R1 mode0");
                    1:       step(3'(c), "R2 R11 mode1");
                    2:       step(3'(c), "R3 mode2");
                    3:       step(3'(c), "R4 mode3");
                    4:       step(3'(c), "R5 mode4");
                    default: step(3'(c), "R6 reserved");
                endcase
            end
        end
    endtask

    task automatic t_unarmed;
        loop_mode = 3'd1; tx_en = 1;
        frame_sync = 0; is_slave = 1;
        for (int c = 0; c < 4; c++) step(3'(c), "R7 no sync");
        frame_sync = 1; is_slave = 0;
        for (int c = 0; c < 4; c++) step(3'(c), "R7 master");
        is_slave = 1;
        step(3'd0, "R7 armed");
        step(3'd2, "R7 armed");
        frame_sync = 0;
        step(3'd2, "R7 sync drop");
        frame_sync = 1;
        step(3'd2, "R7 resync");
    endtask

    task automatic t_phy;
        frame_sync = 1; is_slave = 1; tx_en = 1; phy_loop = 1;
        for (int m = 1; m < 5; m++) begin
            loop_mode = 3'(m);
            step(3'd2, "R8 phy override");
            step(3'd0, "R8 phy override");
        end
        phy_loop = 0;
    endtask

    task automatic t_gate;
        loop_mode = 3'd1; frame_sync = 1; is_slave = 1;
        tx_en = 0; tx_force = 0;
        step(3'd0, "R9 gate closed");
        step(3'd3, "R9 gate closed");
        tx_en = 1;
        step(3'd0, "R9 gate reopen");
    endtask

    task automatic t_force;
        loop_mode = 3'd1; frame_sync = 1; tx_en = 0; tx_force = 1;
        is_slave = 1;
        step(3'd0, "R10 force slave");
        step(3'd4, "R10 force slave");
        is_slave = 0;
        step(3'd0, "R10 force master");
        step(3'd4, "R10 force master");
        tx_force = 0; tx_en = 1; is_slave = 1;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1;
        t_warmup();
        t_reset_after();
        t_modes();
        t_unarmed();
        t_phy();
        t_gate();
        t_force();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // R12: one cycle after a closed gate, the output is back to zero.
    task automatic t_reset_after;
        tx_en = 0;
        step(3'd0, "R12 idle after reset");
        tx_en = 1;
    endtask
endmodule